// File: doc/BRIEF.md
# Bindless Descriptor Address Generator

This block turns a shader's reference to a bindless descriptor into the byte address of that descriptor in memory. It keeps a base register for each of five descriptor tables. There are two copies of these registers: one bank serves every graphics stage and the other serves compute. Each base register also carries the table's descriptor pitch in its two lowest bits. A simple register-write port loads the bases.

A request names a stage class, a 3-bit table selector and a 16-bit descriptor index. The block accepts the request on a valid/ready handshake. One cycle later it presents a registered result: either the computed address, or an error flag when the selector names no table. The result stays on the output until the consumer takes it.

The output controller has two states. `ST_EMPTY` means no result is held. `ST_FULL` means a result is on the output. The transitions are as follows:
- **accept**: `ST_EMPTY` goes to `ST_FULL` when a request is taken.
- **drain**: `ST_FULL` goes to `ST_EMPTY` when the result is taken and no new request arrives.
- **chain**: `ST_FULL` stays in `ST_FULL` when the result is taken and a new request is accepted in the same cycle.
- **stall**: `ST_FULL` stays in `ST_FULL` while `rsp_ready` is low.

Top module: `bdesc_addr_gen`

## Requirements
- R1: After reset all ten base registers read as zero, `rsp_valid` is low and `req_ready` is high.
- R2: The write port addresses tables 0 to 4 through `cfg_set`. A write with `cfg_set` equal to 5, 6 or 7 changes no base register.
- R3: `cfg_compute`/`req_compute` = 1 selects the compute bank and 0 selects the graphics bank. A write to one bank never changes the result of a request to the other bank.
- R4: The address is (base with bits [1:0] cleared) + index × (8 << code), where code is base bits [1:0].
- R5: Pitch codes 0, 1, 2 and 3 give descriptor strides of 8, 16, 32 and 64 bytes.
- R6: A request with selector 5, 6 or 7 returns `rsp_err` = 1 and `rsp_addr` = 0. Selectors 0 to 4 return `rsp_err` = 0.
- R7: The 64-bit sum wraps modulo 2^64 on overflow.
- R8: A request accepted at a clock edge appears on the output with `rsp_valid` high right after that edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_addr` and `rsp_err` hold, `rsp_valid` stays high and `req_ready` is low.
- R10: A base write in the same cycle as an accepted request does not affect that request. It affects only later requests.
- R11: The full 16-bit index range is addressed, up to index 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_compute | input | 1 | Write bank: 1 compute, 0 graphics |
| cfg_set | input | 3 | Table number to write |
| cfg_data | input | 64 | Base value; bits [1:0] are the pitch code |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_compute | input | 1 | Request bank: 1 compute, 0 graphics |
| req_set | input | 3 | Table selector |
| req_index | input | 16 | Descriptor index |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 64 | Descriptor byte address |
| rsp_err | output | 1 | Selector names no table |

## Verification
Two functions can fall in the same cycle: a base register write, and a request that reads that same register. The bench drives both in one cycle with a new base for the table being requested. It expects the address from the old base for that request and the address from the new base for the next one.

Result hand-off and request acceptance can also coincide. A stalled result is released in the same cycle that a waiting request enters. The bench judges this by the value held during the stall and by the value that follows it.

// File: rtl/bdesc_pkg.sv
package bdesc_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_t;

    typedef enum logic {
        CLS_GFX     = 1'b0,
        CLS_COMPUTE = 1'b1
    } stage_cls_t;
endpackage

// File: rtl/bdesc_bank.sv
module bdesc_bank #(
    parameter int NUM_SETS = 5,
    parameter int SEL_W    = 3,
    parameter int ADDR_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_set,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_set,
    output logic [ADDR_W-1:0] rd_base
);
    logic [ADDR_W-1:0] base_q [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[s] <= '0;
            end else if (wr_en && wr_set == SEL_W'(s)) begin
                base_q[s] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_base = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (rd_set == SEL_W'(s)) begin
                rd_base = base_q[s];
            end
        end
    end
endmodule

// File: rtl/bdesc_addr_calc.sv
module bdesc_addr_calc #(
    parameter int NUM_SETS = 5,
    parameter int SEL_W    = 3,
    parameter int IDX_W    = 16,
    parameter int ADDR_W   = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SEL_W-1:0]  set_sel,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] addr,
    output logic              err
);
    localparam int PITCH_W = 2;
    localparam int SHIFT_W = 3;

    logic [PITCH_W-1:0] pitch_code;
    logic [SHIFT_W-1:0] shamt;
    logic [ADDR_W-1:0]  table_base;
    logic [ADDR_W-1:0]  offset;

    always_comb begin
        pitch_code = base[PITCH_W-1:0];
        shamt      = {1'b0, pitch_code} + SHIFT_W'(3);
        table_base = {base[ADDR_W-1:PITCH_W], {PITCH_W{1'b0}}};
        offset     = ADDR_W'(index) << shamt;
        err        = (set_sel >= SEL_W'(NUM_SETS));
        addr       = err ? '0 : (table_base + offset);
    end
endmodule

// File: rtl/bdesc_out_ctrl.sv
module bdesc_out_ctrl
    import bdesc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] calc_addr,
    input  logic              calc_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_err
);
    out_state_t        state_q, state_d;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic              err_q;

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (rsp_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            addr_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= calc_addr;
                err_q  <= calc_err;
            end
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_FULL);
        req_ready = (state_q == ST_EMPTY) || rsp_ready;
        rsp_addr  = addr_q;
        rsp_err   = err_q;
    end
endmodule

// File: rtl/bdesc_addr_gen.sv
module bdesc_addr_gen
    import bdesc_pkg::*;
#(
    parameter int NUM_SETS = 5,
    parameter int SEL_W    = 3,
    parameter int IDX_W    = 16,
    parameter int ADDR_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_compute,
    input  logic [SEL_W-1:0]  cfg_set,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_compute,
    input  logic [SEL_W-1:0]  req_set,
    input  logic [IDX_W-1:0]  req_index,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_err
);
    localparam int NUM_BANKS = 2;

    logic [ADDR_W-1:0] bank_base [NUM_BANKS];
    logic [ADDR_W-1:0] sel_base;
    logic [ADDR_W-1:0] calc_addr;
    logic              calc_err;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bdesc_bank #(
            .NUM_SETS(NUM_SETS),
            .SEL_W   (SEL_W),
            .ADDR_W  (ADDR_W)
        ) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_we && (cfg_compute == b[0])),
            .wr_set (cfg_set),
            .wr_data(cfg_data),
            .rd_set (req_set),
            .rd_base(bank_base[b])
        );
    end

    assign sel_base = (stage_cls_t'(req_compute) == CLS_COMPUTE) ? bank_base[1] : bank_base[0];

    bdesc_addr_calc #(
        .NUM_SETS(NUM_SETS),
        .SEL_W   (SEL_W),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W)
    ) calc_i (
        .base   (sel_base),
        .set_sel(req_set),
        .index  (req_index),
        .addr   (calc_addr),
        .err    (calc_err)
    );

    bdesc_out_ctrl #(
        .ADDR_W(ADDR_W)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .calc_addr(calc_addr),
        .calc_err (calc_err),
        .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready),
        .rsp_addr (rsp_addr),
        .rsp_err  (rsp_err)
    );
endmodule

// File: rtl/bdesc_addr_gen_chk.sv
module bdesc_addr_gen_chk #(
    parameter int NUM_SETS = 5,
    parameter int SEL_W    = 3,
    parameter int ADDR_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SEL_W-1:0]  req_set,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_err
);
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_err)); // R9
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready); // R9
    AST_BAD_SEL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_set >= SEL_W'(NUM_SETS)) |=> rsp_err); // R6
    AST_GOOD_SEL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_set < SEL_W'(NUM_SETS)) |=> !rsp_err); // R6
    AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_addr == '0); // R6
endmodule

bind bdesc_addr_gen bdesc_addr_gen_chk #(
    .NUM_SETS(NUM_SETS),
    .SEL_W   (SEL_W),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_set  (req_set),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_addr (rsp_addr),
    .rsp_err  (rsp_err)
);

// File: tb/bdesc_addr_gen_tb_top.sv
`timescale 1ns/1ps
module bdesc_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_compute = 1'b0;
    logic [2:0]  cfg_set = '0;
    logic [63:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_compute = 1'b0;
    logic [2:0]  req_set = '0;
    logic [15:0] req_index = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_addr;
    logic        rsp_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    bdesc_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_compute(cfg_compute), .cfg_set(cfg_set), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_compute(req_compute),
        .req_set(req_set), .req_index(req_index),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
    );

    function automatic logic [63:0] expect_addr(input logic [63:0] base, input logic [15:0] idx);
        logic [63:0] stride;
        stride = 64'd8 * (64'd1 << base[1:0]);
        return (base & ~64'd3) + 64'(idx) * stride;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_base(input logic comp, input logic [2:0] s, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_compute = comp; cfg_set = s; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input string tag, input logic comp, input logic [2:0] s,
                          input logic [15:0] idx, input logic [63:0] exp_a, input logic exp_e);
        @(negedge clk);
        req_valid = 1'b1; req_compute = comp; req_set = s; req_index = idx;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " err"}, 64'(rsp_err), 64'(exp_e));
        check({tag, " addr"}, rsp_addr, exp_a);
    endtask

    task automatic t_reset();
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 req_ready", 64'(req_ready), 64'd1);
        do_req("R1 gfx zero base", 1'b0, 3'd4, 16'd10, 64'd80, 1'b0);
        do_req("R1 cmp zero base", 1'b1, 3'd0, 16'd3, 64'd24, 1'b0);
    endtask

    task automatic t_pitches();
        logic [63:0] b;
        for (int c = 0; c < 4; c++) begin
            b = 64'h0000_1000_0000_0000 | 64'(c);
            write_base(1'b0, 3'(c), b);
            do_req("R5 pitch", 1'b0, 3'(c), 16'd7, expect_addr(b, 16'd7), 1'b0);
        end
        b = 64'h0000_0000_0040_0002;
        write_base(1'b0, 3'd4, b);
        do_req("R4 set4 formula", 1'b0, 3'd4, 16'd300, expect_addr(b, 16'd300), 1'b0);
        do_req("R11 max index", 1'b0, 3'd3, 16'hFFFF,
               expect_addr(64'h0000_1000_0000_0003, 16'hFFFF), 1'b0);
    endtask

    task automatic t_banks();
        write_base(1'b1, 3'd1, 64'h0000_0000_ABCD_0001);
        do_req("R3 compute bank", 1'b1, 3'd1, 16'd2, 64'h0000_0000_ABCD_0020, 1'b0);
        do_req("R3 gfx untouched", 1'b0, 3'd1, 16'd2, expect_addr(64'h0000_1000_0000_0001, 16'd2), 1'b0);
    endtask

    task automatic t_bad_sel();
        write_base(1'b0, 3'd5, 64'hDEAD_0000_0000_0000);
        do_req("R2 set1 after write to 5", 1'b0, 3'd1, 16'd1, expect_addr(64'h0000_1000_0000_0001, 16'd1), 1'b0);
        for (int s = 5; s < 8; s++) begin
            do_req("R6 bad selector", 1'b0, 3'(s), 16'd9, 64'd0, 1'b1);
        end
    endtask

    task automatic t_wrap();
        write_base(1'b1, 3'd2, 64'hFFFF_FFFF_FFFF_FF03);
        do_req("R7 wrap", 1'b1, 3'd2, 16'd5, 64'h0000_0000_0000_0040, 1'b0);
    endtask

    task automatic t_same_cycle();
        logic [63:0] old_b, new_b;
        old_b = 64'h0000_0000_0040_0002;
        new_b = 64'h0000_0000_0800_0000;
        @(negedge clk);
        cfg_we = 1'b1; cfg_compute = 1'b0; cfg_set = 3'd4; cfg_data = new_b;
        req_valid = 1'b1; req_compute = 1'b0; req_set = 3'd4; req_index = 16'd1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R10 same-cycle uses old", rsp_addr, expect_addr(old_b, 16'd1));
        do_req("R10 later uses new", 1'b0, 3'd4, 16'd1, expect_addr(new_b, 16'd1), 1'b0);
    endtask

    task automatic t_stall();
        logic [63:0] first;
        first = 64'h0000_1000_0000_0000 + 64'd40;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_compute = 1'b0; req_set = 3'd0; req_index = 16'd5;
        @(negedge clk);
        check("R8 valid after one edge", 64'(rsp_valid), 64'd1);
        req_set = 3'd2; req_index = 16'd6;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 held addr", rsp_addr, first);
            check("R9 req_ready low", 64'(req_ready), 64'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 chained next", rsp_addr, expect_addr(64'h0000_1000_0000_0002, 16'd6));
        check("R8 still valid after chain", 64'(rsp_valid), 64'd1);
        @(negedge clk);
        check("R8 drained", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pitches();
        t_banks();
        t_bad_sel();
        t_wrap();
        t_same_cycle();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule